// File: doc/BRIEF.md
# Cascadable Presettable Binary Counter

This block is a synchronous up-counter built by chaining identical 4-bit modulo-16 stages. Every stage can clear, take a parallel preset, count up or hold. Each stage has two count enables. The parallel enable goes to every stage at once. The trickle enable passes from stage to stage through each stage's terminal-count output. Because of this, a wide counter carries across stage boundaries in one clock, with no ripple clocking.

A parameter chooses the reset style for the whole block. In the asynchronous style, the count clears as soon as reset goes low. In the synchronous style, the count clears on the next rising clock edge. The terminal-count flag of the last stage is brought out so that several counters can be chained further, or so the block can act as a programmable divider: preset a start value and reload it whenever the flag rises.

Top module: `cascade_counter`

## Requirements
- R1: With the asynchronous reset style selected (ASYNC_CLR=1), a low `rst_n` forces `count` to zero at once, without waiting for a clock edge, and holds it at zero while `rst_n` stays low.
- R2: With the synchronous reset style selected (ASYNC_CLR=0), a low `rst_n` leaves `count` unchanged until the next rising edge of `clk`, and that edge sets `count` to zero.
- R3: When `rst_n` is high and `load_n` is low at a rising edge, `count` takes the value of `par_data` on that edge, whatever the two enables are.
- R4: When `rst_n` and `load_n` are high and both `en_par` and `en_trickle` are high at a rising edge, `count` increases by one on that edge.
- R5: When `rst_n` and `load_n` are high and either `en_par` or `en_trickle` is low at a rising edge, `count` keeps its value.
- R6: If the counter counts while it holds the all-ones value, it wraps to zero.
- R7: `term_cnt` is high exactly when `count` is all ones and `en_trickle` is high. It follows `en_trickle` combinationally, with no clock edge in between.
- R8: The 4-bit field in bits [4k+3:4k] of `count` advances only on a counting edge where every lower field is 15. For example, 0x0FF counts to 0x100.
- R9: Reset takes precedence over load. A low `rst_n` together with a low `load_n` gives zero, not `par_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low clear; asynchronous or synchronous according to ASYNC_CLR |
| load_n | input | 1 | Active-low parallel preset enable |
| par_data | input | 4*STAGES | Preset value |
| en_par | input | 1 | Count enable shared by all stages |
| en_trickle | input | 1 | Count enable into the lowest stage; also gates `term_cnt` |
| count | output | 4*STAGES | Counter value |
| term_cnt | output | 1 | High at all ones while `en_trickle` is high |

## Verification
Clear, preset and count can all be requested in the same cycle. The precedence among them is the main risk. The bench drives load together with both enables, and expects the preset value rather than an increment. It also drops reset while load is low, and expects zero from both reset styles. It checks the asynchronous instance right away, and checks that the synchronous instance does not change until the next edge. A second overlap involves the terminal-count flag: the flag changes with the trickle enable while the stored count stays fixed, so the bench checks the flag between edges as well as after them.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
  localparam int NIB = 4;

  typedef enum logic [1:0] {
    MODE_HOLD  = 2'd0,
    MODE_COUNT = 2'd1,
    MODE_LOAD  = 2'd2,
    MODE_CLEAR = 2'd3
  } mode_e;
endpackage

// File: rtl/cnt_mode_sel.sv
module cnt_mode_sel
  import cnt_pkg::*;
#(
  parameter bit SYNC_CLR = 1'b0
) (
  input  logic  rst_n,
  input  logic  load_n,
  input  logic  en_p,
  input  logic  en_t,
  output mode_e mode
);
  // Fixed precedence: clear, preset, count, hold.
  always_comb begin
    if (SYNC_CLR && !rst_n)   mode = MODE_CLEAR;
    else if (!load_n)         mode = MODE_LOAD;
    else if (en_p && en_t)    mode = MODE_COUNT;
    else                      mode = MODE_HOLD;
  end
endmodule

// File: rtl/cnt_nibble.sv
module cnt_nibble
  import cnt_pkg::*;
#(
  parameter bit ASYNC_CLR = 1'b1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load_n,
  input  logic [NIB-1:0] din,
  input  logic           en_p,
  input  logic           en_t,
  output logic [NIB-1:0] q,
  output logic           tc
);
  mode_e          mode;
  logic [NIB-1:0] q_r;
  logic [NIB-1:0] q_nx;
  logic           upd;

  cnt_mode_sel #(.SYNC_CLR(!ASYNC_CLR)) u_sel (
    .rst_n  (rst_n),
    .load_n (load_n),
    .en_p   (en_p),
    .en_t   (en_t),
    .mode   (mode)
  );

  // Next-state selection
  always_comb begin
    case (mode)
      MODE_CLEAR: q_nx = '0;
      MODE_LOAD:  q_nx = din;
      MODE_COUNT: q_nx = q_r + 1'b1;
      default:    q_nx = q_r;
    endcase
  end

  assign upd = (mode != MODE_HOLD);

  // State register, reset style picked by parameter
  generate
    if (ASYNC_CLR) begin : g_async
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   q_r <= '0;
        else if (upd) q_r <= q_nx;
      end
    end else begin : g_sync
      always_ff @(posedge clk) begin
        if (upd) q_r <= q_nx;
      end
    end
  endgenerate

  assign q  = q_r;
  assign tc = (&q_r) & en_t;
endmodule

// File: rtl/cascade_counter.sv
module cascade_counter
  import cnt_pkg::*;
#(
  parameter int STAGES    = 3,
  parameter bit ASYNC_CLR = 1'b1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load_n,
  input  logic [STAGES*NIB-1:0]   par_data,
  input  logic                    en_par,
  input  logic                    en_trickle,
  output logic [STAGES*NIB-1:0]   count,
  output logic                    term_cnt
);
  localparam int W = STAGES * NIB;

  logic [STAGES:0] carry;
  logic [W-1:0]    q_all;

  assign carry[0] = en_trickle;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      cnt_nibble #(.ASYNC_CLR(ASYNC_CLR)) u_nib (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_n (load_n),
        .din    (par_data[i*NIB +: NIB]),
        .en_p   (en_par),
        .en_t   (carry[i]),
        .q      (q_all[i*NIB +: NIB]),
        .tc     (carry[i+1])
      );
    end
  endgenerate

  assign count    = q_all;
  assign term_cnt = carry[STAGES];
endmodule

// File: rtl/counter_checker.sv
module counter_checker #(
  parameter int W         = 12,
  parameter bit ASYNC_CLR = 1'b1
) (
  input logic         clk,
  input logic         rst_n,
  input logic         load_n,
  input logic [W-1:0] par_data,
  input logic         en_par,
  input logic         en_trickle,
  input logic [W-1:0] count,
  input logic         term_cnt
);
  assert_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_n) |=> (count == $past(par_data)))
    else $error("preset not taken");

  assert_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && en_par && en_trickle) |=> (count == W'($past(count) + 1'b1)))
    else $error("increment missing");

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && !(en_par && en_trickle)) |=> $stable(count))
    else $error("hold violated");

  assert_tc_R7: assert property (@(posedge clk) disable iff (!rst_n)
    term_cnt == ((&count) && en_trickle))
    else $error("terminal count mismatch");

  generate
    if (ASYNC_CLR) begin : g_async_chk
      always @(posedge clk) begin
        if (!rst_n) begin
          assert_clear_R1: assert (count == '0)
            else $error("count not cleared under reset");
        end
      end
    end
  endgenerate
endmodule

bind cascade_counter counter_checker #(
  .W         (STAGES * cnt_pkg::NIB),
  .ASYNC_CLR (ASYNC_CLR)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .load_n     (load_n),
  .par_data   (par_data),
  .en_par     (en_par),
  .en_trickle (en_trickle),
  .count      (count),
  .term_cnt   (term_cnt)
);

// File: tb/cascade_counter_test.sv
`timescale 1ns/1ps
module cascade_counter_test;
  localparam int STG  = 3;
  localparam int W    = STG * 4;
  localparam int MAXV = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         load_n;
  logic [W-1:0] par_data;
  logic         en_par;
  logic         en_trickle;
  logic [W-1:0] cnt_a, cnt_s;
  logic         tc_a, tc_s;

  int errors = 0;
  int checks = 0;
  int ma = 0;
  int ms = 0;
  bit done = 0;

  always #2 clk = ~clk;

  cascade_counter #(.STAGES(STG), .ASYNC_CLR(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .load_n(load_n), .par_data(par_data),
    .en_par(en_par), .en_trickle(en_trickle), .count(cnt_a), .term_cnt(tc_a));

  cascade_counter #(.STAGES(STG), .ASYNC_CLR(1'b0)) uut_s (
    .clk(clk), .rst_n(rst_n), .load_n(load_n), .par_data(par_data),
    .en_par(en_par), .en_trickle(en_trickle), .count(cnt_s), .term_cnt(tc_s));

  function automatic int next_val(int cur);
    if (!rst_n)                   return 0;
    if (!load_n)                  return int'(par_data);
    if (en_par && en_trickle)     return (cur + 1) & MAXV;
    return cur;
  endfunction

  task automatic expect_eq(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic check(string req, bit with_sync);
    if ($isunknown(cnt_a)) expect_eq(req, "async count known", 1, 0);
    else expect_eq(req, "async count", int'(cnt_a), ma);
    expect_eq(req, "async tc", int'(tc_a), int'(ma == MAXV && en_trickle));
    if (with_sync) begin
      if ($isunknown(cnt_s)) expect_eq(req, "sync count known", 1, 0);
      else expect_eq(req, "sync count", int'(cnt_s), ms);
      expect_eq(req, "sync tc", int'(tc_s), int'(ms == MAXV && en_trickle));
    end
  endtask

  // One clock: models advance from the inputs held across the edge
  task automatic tick(string req);
    @(posedge clk);
    ma = next_val(ma);
    ms = next_val(ms);
    #1;
    check(req, 1'b1);
  endtask

  task automatic drop_reset();
    rst_n = 1'b0;
    ma = 0;
    #0.5;
  endtask

  initial begin
    rst_n = 1'b1; load_n = 1'b1; par_data = '0; en_par = 1'b0; en_trickle = 1'b0;
    #1;
    drop_reset();
    check("R1", 1'b0);                 // async cleared before any edge
    tick("R2"); tick("R2");            // sync cleared by the edge

    // R3: preset with both enables high, load wins
    rst_n = 1'b1; load_n = 1'b0; par_data = 12'h0FD; en_par = 1'b1; en_trickle = 1'b1;
    tick("R3");
    load_n = 1'b1;
    tick("R4"); tick("R4");            // 0FE, 0FF
    tick("R8");                        // 0FF -> 100 across two fields

    // R5: either enable low holds
    en_par = 1'b0; tick("R5"); tick("R5");
    en_par = 1'b1; en_trickle = 1'b0; tick("R5"); tick("R5");

    // R7: terminal count at all ones, combinational in en_trickle
    load_n = 1'b0; par_data = 12'hFFE; tick("R3");
    load_n = 1'b1; en_trickle = 1'b1; tick("R4");
    check("R7", 1'b1);
    en_trickle = 1'b0; #0.5; check("R7", 1'b1);
    tick("R7");
    en_trickle = 1'b1; #0.5; check("R7", 1'b1);
    tick("R6");                        // FFF -> 000

    // R9: reset with load, mid-cycle
    load_n = 1'b0; par_data = 12'h123; tick("R3");
    load_n = 1'b0; par_data = 12'h456;
    drop_reset();
    check("R1", 1'b1);                 // async zero now, sync still 123
    expect_eq("R2", "sync holds before edge", int'(cnt_s), 12'h123);
    tick("R9");
    rst_n = 1'b1; load_n = 1'b1;
    tick("R4");

    // mixed stimulus
    for (int i = 0; i < 400; i++) begin
      load_n     = ($urandom_range(0, 7) != 0);
      en_par     = ($urandom_range(0, 3) != 0);
      en_trickle = ($urandom_range(0, 3) != 0);
      par_data   = W'($urandom_range(0, MAXV));
      if ($urandom_range(0, 31) == 0) drop_reset();
      else rst_n = 1'b1;
      if (i % 50 == 0) begin
        load_n = 1'b0; par_data = 12'hFF0 - W'(i % 3);
      end
      tick("R4");
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule